// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit copies the value of a free-running 16-bit timer into a holding register when a qualified event occurs on an external capture input. The input is brought into the clock domain by a two-stage synchronizer. An edge detector follows the synchronizer. A 4-bit mode field selects the qualifying event: every falling edge, every rising edge, every 4th rising edge or every 16th rising edge. The same field can also switch the unit off. A select input picks which of two timer buses is sampled.

Each capture sets a sticky interrupt flag, and software clears it with a one-cycle clear strobe. A new capture replaces the held value even if software has not read the previous one. The rising-edge prescaler keeps its count when the mode moves from one capture mode to another. Any non-capture mode clears the count, and so does reset. Software that wants a clean start turns the unit off before it selects a new ratio. The timers are synchronous to the unit's clock.

Top module: `tcap_unit`

## Requirements
- R1: After reset, `cap_value` is 0 and `cap_flag` is 0.
- R2: With mode 4'b0100, each falling edge of `cap_in` causes a capture. Rising edges cause none.
- R3: With mode 4'b0101, each rising edge of `cap_in` causes a capture. Falling edges cause none.
- R4: With mode 4'b0110, every 4th rising edge causes a capture, counted from a cleared prescaler. The first three rising edges cause none.
- R5: With mode 4'b0111, every 16th rising edge causes a capture, counted from a cleared prescaler.
- R6: A capture is visible on `cap_value` and `cap_flag` after the third rising clock edge that follows a change of `cap_in`. It is not visible after the second.
- R7: A capture loads `timer_a` when `tsel` is 0 and `timer_b` when `tsel` is 1. The value loaded is the one present at the capturing clock edge.
- R8: A second capture overwrites `cap_value` even if the first value was never read.
- R9: `cap_flag` stays set until a cycle with `flag_clr` high and no capture. If a capture and `flag_clr` occur in the same cycle, the flag stays set.
- R10: In mode 4'b0000 and in every code other than 4'b0100 to 4'b0111, no capture occurs and the prescaler count is cleared. After re-entering mode 4'b0110, a full four rising edges are needed.
- R11: A direct change between capture modes keeps the prescaler count. Three rising edges in mode 4'b0111, followed by a switch to 4'b0110, make the next rising edge capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_in | input | 1 | External capture input, asynchronous |
| mode | input | 4 | Event and prescale selection, 4'b0000 = off |
| tsel | input | 1 | Timer source select, 0 = timer_a, 1 = timer_b |
| timer_a | input | 16 | First timer value |
| timer_b | input | 16 | Second timer value |
| flag_clr | input | 1 | Software clear strobe for the capture flag |
| cap_value | output | 16 | Captured timer value |
| cap_flag | output | 1 | Sticky capture interrupt flag |

## Verification
A capture becomes visible three clock edges after the capture input changes. Two of those edges are synchronizer stages and the third loads the holding register and the flag. The bench changes `cap_in` on a falling clock edge and samples on falling edges. In the latency case it checks that the flag is still low after two rising edges and high after the third. The flag-clear race is timed so that `flag_clr` is high exactly on that third edge. Each expected capture is queued before its edge is driven. The monitor pops the queue on each new rise of the flag, so early or spurious captures show up as unexpected pops.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int MODE_W = 4;
  localparam int PS_W   = 4;

  typedef enum logic [2:0] {
    EV_OFF, EV_FALL, EV_RISE, EV_RISE4, EV_RISE16
  } ev_kind_t;

  function automatic ev_kind_t decode_mode(input logic [MODE_W-1:0] m);
    case (m)
      4'b0100: return EV_FALL;
      4'b0101: return EV_RISE;
      4'b0110: return EV_RISE4;
      4'b0111: return EV_RISE16;
      default: return EV_OFF;
    endcase
  endfunction

  function automatic logic uses_prescaler(input ev_kind_t k);
    return (k == EV_RISE4) || (k == EV_RISE16);
  endfunction

  // terminal count of the prescaler: ratio minus one
  function automatic logic [PS_W-1:0] prescale_last(input ev_kind_t k);
    case (k)
      EV_RISE4:  return PS_W'(3);
      EV_RISE16: return PS_W'(15);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int TOP = STAGES;

  logic [TOP:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[TOP-1:0], din};
  end

  assign rise =  sh[TOP-1] & ~sh[TOP];
  assign fall = ~sh[TOP-1] &  sh[TOP];
endmodule

// File: rtl/tcap_prescale.sv
module tcap_prescale #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         active,
  input  logic         rise_in,
  input  logic [W-1:0] last,
  output logic         hit,
  output logic [W-1:0] cnt
);
  logic at_last;

  assign at_last = (cnt >= last);
  assign hit     = active & rise_in & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (active && rise_in) cnt <= at_last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit #(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap_in,
  input  logic [tcap_pkg::MODE_W-1:0] mode,
  input  logic                       tsel,
  input  logic [TW-1:0]              timer_a,
  input  logic [TW-1:0]              timer_b,
  input  logic                       flag_clr,
  output logic [TW-1:0]              cap_value,
  output logic                       cap_flag
);
  import tcap_pkg::*;

  ev_kind_t        kind;
  logic            cap_mode;
  logic            ps_active;
  logic            edge_rise;
  logic            edge_fall;
  logic            ps_hit;
  logic [PS_W-1:0] ps_cnt;
  logic            fire;
  logic [TW-1:0]   tsample;

  assign kind      = decode_mode(mode);
  assign cap_mode  = (kind != EV_OFF);
  assign ps_active = uses_prescaler(kind);
  assign tsample   = tsel ? timer_b : timer_a;

  tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .rise (edge_rise),
    .fall (edge_fall)
  );

  tcap_prescale #(.W(PS_W)) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!cap_mode),
    .active (ps_active),
    .rise_in(edge_rise),
    .last   (prescale_last(kind)),
    .hit    (ps_hit),
    .cnt    (ps_cnt)
  );

  always_comb begin
    case (kind)
      EV_FALL:   fire = edge_fall;
      EV_RISE:   fire = edge_rise;
      EV_RISE4,
      EV_RISE16: fire = ps_hit;
      default:   fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else begin
      if (fire) cap_value <= tsample;
      if (fire)          cap_flag <= 1'b1;
      else if (flag_clr) cap_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          tsel,
  input logic [TW-1:0] timer_a,
  input logic [TW-1:0] timer_b,
  input logic          flag_clr,
  input logic [TW-1:0] cap_value,
  input logic          cap_flag,
  input logic          fire,
  input logic          cap_mode,
  input logic [3:0]    ps_cnt
);
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag);

  // R9
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cap_flag);

  // R7
  source_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cap_value == $past(tsel ? timer_b : timer_a)));

  // R10
  off_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_mode |=> $stable(cap_value));

  // R10
  off_clears_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_mode |=> (ps_cnt == 4'd0));

  // R4
  div4_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'b0110 && fire) |=> (ps_cnt == 4'd0));
endmodule

bind tcap_unit tcap_unit_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .tsel     (tsel),
  .timer_a  (timer_a),
  .timer_b  (timer_b),
  .flag_clr (flag_clr),
  .cap_value(cap_value),
  .cap_flag (cap_flag),
  .fire     (fire),
  .cap_mode (cap_mode),
  .ps_cnt   (ps_cnt)
);

// File: tb/sim_tcap_unit.sv
module sim_tcap_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic [3:0]  mode = 4'b0000;
  logic        tsel = 1'b0;
  logic [15:0] timer_a = '0;
  logic [15:0] timer_b = '0;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        prev_flag = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcap_unit u0 (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .mode(mode), .tsel(tsel),
    .timer_a(timer_a), .timer_b(timer_b), .flag_clr(flag_clr),
    .cap_value(cap_value), .cap_flag(cap_flag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_cap(input logic [15:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // monitor: each new rise of the flag must match a queued capture
  always @(negedge clk) begin
    if (rst_n && !done && cap_flag && !prev_flag) begin
      if (exp_q.size() == 0) check("unexpected capture", cap_value, 16'hxxxx);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, cap_value, e);
      end
    end
    prev_flag <= cap_flag;
  end

  task automatic set_in(input logic v);
    @(negedge clk);
    cap_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse();
    set_in(1'b1);
    set_in(1'b0);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    timer_a = 16'h1234;
    timer_b = 16'hBEEF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 value", cap_value, 16'h0000);
    check("R1 flag", {15'b0, cap_flag}, 16'h0001 & 16'h0000);
    rst_n = 1'b1;

    // R3 rising mode, R6 latency, R7 timer_a
    mode = 4'b0101;
    @(negedge clk);
    expect_cap(16'h1234, "R3/R7 rising capture of timer_a");
    cap_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 not yet after two edges", {15'b0, cap_flag}, 16'h0000);
    @(negedge clk);
    check("R6 visible after third edge", {15'b0, cap_flag}, 16'h0001);
    clear_flag();
    check("R9 flag cleared", {15'b0, cap_flag}, 16'h0000);
    set_in(1'b0);
    check("R3 falling edge ignored", {15'b0, cap_flag}, 16'h0000);

    // R2 falling mode, R7 timer_b
    mode = 4'b0100; tsel = 1'b1; timer_b = 16'h5A5A;
    set_in(1'b1);
    check("R2 rising edge ignored", {15'b0, cap_flag}, 16'h0000);
    expect_cap(16'h5A5A, "R2/R7 falling capture of timer_b");
    set_in(1'b0);
    clear_flag();
    tsel = 1'b0;

    // R4 divide by 4
    mode = 4'b0110; timer_a = 16'h4444;
    for (int i = 0; i < 3; i++) pulse();
    check("R4 no capture before 4th edge", {15'b0, cap_flag}, 16'h0000);
    expect_cap(16'h4444, "R4 capture on 4th edge");
    pulse();
    clear_flag();

    // R5 divide by 16
    mode = 4'b0111; timer_a = 16'h1616;
    for (int i = 0; i < 15; i++) pulse();
    check("R5 no capture before 16th edge", {15'b0, cap_flag}, 16'h0000);
    expect_cap(16'h1616, "R5 capture on 16th edge");
    pulse();
    clear_flag();

    // R10 off and other non-capture codes
    mode = 4'b0000; timer_a = 16'hDEAD;
    pulse(); pulse();
    mode = 4'b1000;
    pulse();
    check("R10 no flag when off", {15'b0, cap_flag}, 16'h0000);
    check("R10 value unchanged when off", cap_value, 16'h1616);

    // R10 prescaler cleared by leaving capture mode
    mode = 4'b0110; timer_a = 16'h0A0A;
    pulse(); pulse();
    mode = 4'b0000;
    repeat (2) @(negedge clk);
    mode = 4'b0110;
    for (int i = 0; i < 3; i++) pulse();
    check("R10 prescaler restarted", {15'b0, cap_flag}, 16'h0000);
    expect_cap(16'h0A0A, "R10 capture after full count");
    pulse();
    clear_flag();

    // R11 count kept across a direct mode change
    mode = 4'b0111; timer_a = 16'h0B0B;
    for (int i = 0; i < 3; i++) pulse();
    mode = 4'b0110;
    expect_cap(16'h0B0B, "R11 early capture after ratio change");
    pulse();
    clear_flag();

    // R8 overwrite without read
    mode = 4'b0101; timer_a = 16'h1111;
    expect_cap(16'h1111, "R8 first capture");
    pulse();
    timer_a = 16'h2222;
    pulse();
    check("R8 overwritten value", cap_value, 16'h2222);

    // R9 capture and clear in the same cycle: capture wins
    timer_a = 16'h3333;
    @(negedge clk);
    cap_in = 1'b1;
    repeat (2) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R9 flag kept on simultaneous clear", {15'b0, cap_flag}, 16'h0001);
    check("R9 value from simultaneous capture", cap_value, 16'h3333);
    clear_flag();
    check("R9 flag cleared afterwards", {15'b0, cap_flag}, 16'h0000);
    set_in(1'b0);

    repeat (4) @(negedge clk);
    check("all queued captures seen", 16'(exp_q.size()), 16'h0000);
    finish_up();
  end
endmodule